// File: doc/BRIEF.md
# Two-Wire Serial Programmer Host Sequencer

This block is the host side of a two-wire in-system programming link. It drives a clock line and a bidirectional data line toward a target flash device. A single request carries a 6-bit opcode and an optional 14-bit payload. For that request the block produces the clock pulses and presents the bits least significant first. It inserts the guard delays the target needs between phases and between commands. On read opcodes it releases the data line and collects the word the target returns.

On top of single commands the block runs three macro sequences. Bulk erase loads an all-ones word and then issues the erase opcode. Program-and-verify of one word loads the word, starts programming, waits, reads the word back, compares it and, on a match, steps the target address. Mode entry raises the entry output while clock and data stay low, then waits before any clock may run. Every delay is a parameter counted in system-clock cycles. A request finishes with a one-cycle `done` pulse, and `err` is valid with that pulse.

Top module: `serprog_seq`

## Requirements
- R1: After reset `busy`, `done`, `pclk`, `pdat_o` and `mode_en` are 0 and `pdat_oe` is 1.
- R2: A command phase is 6 pulses on `pclk`, each high for T_HALF cycles and low for T_HALF cycles. Opcode bit 0 goes first. Each bit is on `pdat_o` from the rising edge until the next rising edge, so it is stable across the falling edge.
- R3: Opcodes whose low nibble is 0x0, 0x2, 0x3, 0x4 or 0x5 have a data phase. After the last command falling edge, `pclk` stays low for T_HALF+T_GAP cycles. Then 16 pulses follow, carrying 0, payload bits 0..13, then 0.
- R4: On read opcodes (low nibble 0x4 or 0x5), `pdat_oe` is 0 for the whole data phase. `pdat_i` is sampled in the last cycle of each high phase. `rd_data` then holds received bits 1..14.
- R5: After a step's last falling edge, `pclk` stays low and `busy` stays 1 for T_HALF plus a post delay before `done` pulses for one cycle and `busy` falls. The post delay is T_GAP by default. For an erase opcode (low nibble 0x9 or 0xB) it is T_ERASE. For begin-programming (bits 4..0 = 01000) it is T_DPROG if the most recent load opcode was 0x3, and T_PROG otherwise.
- R6: A raw begin-programming request is rejected when no load opcode (low nibble 0x0, 0x2, 0x3) has been sent since the last begin-programming or mode entry. The rejection gives `done` with `err`=1 one cycle after acceptance and produces no clock pulse.
- R7: The erase macro (kind 1) sends opcode 0x02 with payload 0x3FFF and then opcode 0x09, and ends after the erase post delay with `err`=0.
- R8: The program-verify macro (kind 2) sends 0x02 with the payload, then 0x08, then read opcode 0x04. If the word read back equals the payload, it sends 0x06 and ends with `err`=0. If it differs, it ends after the read with `err`=1 and sends no 0x06.
- R9: Mode entry (kind 3) raises `mode_en`, which then stays 1. Clock and data stay low with no pulse, and `done` arrives T_ENTRY cycles after acceptance.
- R10: `req_valid` is ignored while `busy` is 1: the waveform in progress is unchanged and no extra `done` appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken while idle |
| req_kind | input | 2 | 0 raw command, 1 erase macro, 2 program-verify macro, 3 mode entry |
| req_cmd | input | 6 | Opcode for raw commands |
| req_data | input | 14 | Payload for loads and the word to program |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Failure flag, valid with `done` |
| rd_data | output | 14 | Last word received by a read |
| mode_en | output | 1 | Programming mode entry control |
| pclk | output | 1 | Serial clock to target |
| pdat_o | output | 1 | Serial data driven to target |
| pdat_oe | output | 1 | Data line drive enable (0 = released) |
| pdat_i | input | 1 | Serial data from target |

## Verification
A wrong bit counter or phase flag shows within one command as a wrong pulse count, a bit in the wrong slot, or a low gap of the wrong length. A stale load or memory-type flag shows only at the next begin-programming: it gives the wrong post delay or a spurious rejection, so the bench runs begin-programming after every kind of load and after mode entry. A wrong comparison in the verify macro shows at the end of that request, as the presence or absence of the increment opcode and the state of `err`.

// File: rtl/serprog_seq.sv
module serprog_seq #(
  parameter int T_HALF  = 13,
  parameter int T_GAP   = 125,
  parameter int T_ENTRY = 625,
  parameter int T_PROG  = 312500,
  parameter int T_DPROG = 750000,
  parameter int T_ERASE = 750000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [1:0]  req_kind,
  input  logic [5:0]  req_cmd,
  input  logic [13:0] req_data,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic [13:0] rd_data,
  output logic        mode_en,
  output logic        pclk,
  output logic        pdat_o,
  output logic        pdat_oe,
  input  logic        pdat_i
);
  localparam int M1 = (T_PROG > T_DPROG) ? T_PROG : T_DPROG;
  localparam int M2 = (M1 > T_ERASE) ? M1 : T_ERASE;
  localparam int M3 = (M2 > T_ENTRY) ? M2 : T_ENTRY;
  localparam int M4 = (M3 > T_GAP) ? M3 : T_GAP;
  localparam int MX = (M4 > T_HALF) ? M4 : T_HALF;
  localparam int TW = $clog2(MX + 1);

  localparam logic [1:0] K_RAW = 2'd0, K_ERASE = 2'd1, K_PROG = 2'd2, K_ENTRY = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_ENTRY, S_CMD, S_GAP, S_DATA, S_POST} st_t;

  function automatic logic f_has(input logic [5:0] c);
    return c[3:0] inside {4'h0, 4'h2, 4'h3, 4'h4, 4'h5};
  endfunction
  function automatic logic f_rd(input logic [5:0] c);
    return c[3:0] inside {4'h4, 4'h5};
  endfunction
  function automatic logic f_ld(input logic [5:0] c);
    return c[3:0] inside {4'h0, 4'h2, 4'h3};
  endfunction
  function automatic logic f_beg(input logic [5:0] c);
    return c[4:0] == 5'b01000;
  endfunction
  function automatic logic f_era(input logic [5:0] c);
    return c[3:0] inside {4'h9, 4'hB};
  endfunction
  function automatic logic [5:0] f_step(input logic [1:0] k, input logic [1:0] s, input logic [5:0] raw);
    logic [5:0] r;
    r = raw;
    if (k == K_ERASE) r = (s == 2'd0) ? 6'h02 : 6'h09;
    else if (k == K_PROG) begin
      case (s)
        2'd0:    r = 6'h02;
        2'd1:    r = 6'h08;
        2'd2:    r = 6'h04;
        default: r = 6'h06;
      endcase
    end
    return r;
  endfunction

  st_t         st;
  logic [TW-1:0] tmr, post_m1;
  logic        hi, loaded, dmem;
  logic [3:0]  bitn;
  logic [1:0]  kind, step;
  logic [5:0]  cmd, nxt_cmd;
  logic [13:0] wdata, sdata;
  logic [15:0] rx, dframe;
  logic        tick, rdc, mism, last_step, reject, launch;

  assign tick    = (tmr == '0);
  assign rdc     = f_rd(cmd);
  assign sdata   = (kind == K_ERASE) ? 14'h3FFF : wdata;
  assign dframe  = {1'b0, sdata, 1'b0};
  assign mism    = (rx[14:1] != wdata);
  assign rd_data = rx[14:1];
  assign busy    = (st != S_IDLE);
  assign pclk    = (st == S_CMD || st == S_DATA) && hi;
  assign pdat_oe = !(st == S_DATA && rdc);
  assign pdat_o  = (st == S_CMD) ? cmd[bitn[2:0]] :
                   (st == S_DATA && !rdc) ? dframe[bitn] : 1'b0;

  assign last_step = (kind == K_RAW) || (kind == K_ERASE && step == 2'd1) ||
                     (kind == K_PROG && (step == 2'd3 || (step == 2'd2 && mism)));
  assign nxt_cmd = (st == S_IDLE) ? f_step(req_kind, 2'd0, req_cmd) : f_step(kind, step + 2'd1, cmd);
  assign reject  = (req_kind == K_RAW) && f_beg(req_cmd) && !loaded;
  assign launch  = (st == S_IDLE && req_valid && req_kind != K_ENTRY && !reject) ||
                   (st == S_POST && tick && !last_step);

  always_comb begin
    if (f_beg(cmd))      post_m1 = dmem ? TW'(T_DPROG - 1) : TW'(T_PROG - 1);
    else if (f_era(cmd)) post_m1 = TW'(T_ERASE - 1);
    else                 post_m1 = TW'(T_GAP - 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; tmr <= '0; hi <= 1'b0; bitn <= '0; kind <= K_RAW; step <= '0;
      cmd <= '0; wdata <= '0; rx <= '0; loaded <= 1'b0; dmem <= 1'b0;
      done <= 1'b0; err <= 1'b0; mode_en <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          if (req_kind == K_ENTRY) begin
            st <= S_ENTRY; mode_en <= 1'b1; loaded <= 1'b0; tmr <= TW'(T_ENTRY - 1);
          end else if (reject) begin
            done <= 1'b1; err <= 1'b1;
          end else begin
            kind <= req_kind; step <= '0; wdata <= req_data;
          end
        end
        S_ENTRY: if (tick) begin st <= S_IDLE; done <= 1'b1; err <= 1'b0; end
                 else tmr <= tmr - 1'b1;
        S_CMD, S_DATA: begin
          if (!tick) tmr <= tmr - 1'b1;
          else if (hi) begin
            hi <= 1'b0; tmr <= TW'(T_HALF - 1);
            if (st == S_DATA && rdc) rx[bitn] <= pdat_i;
          end else if (bitn == ((st == S_CMD) ? 4'd5 : 4'd15)) begin
            if (st == S_CMD && f_has(cmd)) begin st <= S_GAP; tmr <= TW'(T_GAP - 1); end
            else begin st <= S_POST; tmr <= post_m1; end
          end else begin
            bitn <= bitn + 4'd1; hi <= 1'b1; tmr <= TW'(T_HALF - 1);
          end
        end
        S_GAP: if (tick) begin st <= S_DATA; bitn <= '0; hi <= 1'b1; tmr <= TW'(T_HALF - 1); end
               else tmr <= tmr - 1'b1;
        S_POST: if (tick) begin
          if (last_step) begin st <= S_IDLE; done <= 1'b1; err <= (kind == K_PROG) && mism; end
          else step <= step + 2'd1;
        end else tmr <= tmr - 1'b1;
        default: st <= S_IDLE;
      endcase
      if (launch) begin
        st <= S_CMD; cmd <= nxt_cmd; bitn <= '0; hi <= 1'b1; tmr <= TW'(T_HALF - 1);
        if (f_ld(nxt_cmd)) begin loaded <= 1'b1; dmem <= (nxt_cmd[3:0] == 4'h3); end
        if (f_beg(nxt_cmd)) loaded <= 1'b0;
      end
    end
  end

  AST_CLK_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) pclk |-> busy); // R2
  AST_DAT_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) pclk && $past(pclk) |-> $stable(pdat_o)); // R2
  AST_DAT_STABLE_FALL: assert property (@(posedge clk) disable iff (!rst_n) $fell(pclk) |-> $stable(pdat_o)); // R2
  AST_RELEASE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n) !pdat_oe |-> busy); // R4
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R5
  AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done); // R5
  AST_MODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) mode_en |=> mode_en); // R9
  AST_ENTRY_QUIET: assert property (@(posedge clk) disable iff (!rst_n) $rose(mode_en) |-> !pclk && !pdat_o); // R9
endmodule

// File: tb/serprog_seq_tb_top.sv
module serprog_seq_tb_top;
  localparam int HALF = 2, GAP = 3, ENTRY = 7, PROG = 20, DPROG = 30, ERASE = 40;
  localparam logic [1:0] K_RAW = 2'd0, K_ERASE = 2'd1, K_PROG = 2'd2, K_ENTRY = 2'd3;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic req_valid = 1'b0;
  logic [1:0] req_kind = '0;
  logic [5:0] req_cmd = '0;
  logic [13:0] req_data = '0;
  logic busy, done, err, mode_en, pclk, pdat_o, pdat_oe;
  logic pdat_i = 1'b0;
  logic [13:0] rd_data;

  serprog_seq #(.T_HALF(HALF), .T_GAP(GAP), .T_ENTRY(ENTRY), .T_PROG(PROG),
                .T_DPROG(DPROG), .T_ERASE(ERASE)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind), .req_cmd(req_cmd),
    .req_data(req_data), .busy(busy), .done(done), .err(err), .rd_data(rd_data),
    .mode_en(mode_en), .pclk(pclk), .pdat_o(pdat_o), .pdat_oe(pdat_oe), .pdat_i(pdat_i));

  int nchk = 0, nfail = 0;
  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    nchk++;
    if (!ok) begin nfail++; $display("FAIL %s: actual %0d expected %0d", rq, act, exp); end
  endtask

  int np = 0, lowrun = 0, hirun = 0, hi_bad = 0, since_fall = 0, ndone = 0, f2d = 0, rcnt = 0;
  bit prev = 1'b0;
  bit log_bit[128], log_oe[128];
  int log_low[128];
  logic [15:0] rframe = '0;

  always @(negedge clk) if (rst_n) begin
    if (pdat_oe) rcnt = 0;
    since_fall++;
    if (pclk && !prev) begin
      if (np < 128) begin log_bit[np] = pdat_o; log_oe[np] = pdat_oe; log_low[np] = lowrun; end
      np++; hirun = 1;
      if (!pdat_oe) begin pdat_i = rframe[rcnt[3:0]]; rcnt++; end
    end else if (pclk) hirun++;
    else if (prev) begin
      if (hirun != HALF) hi_bad++;
      lowrun = 1; since_fall = 0;
    end else lowrun++;
    if (done) begin ndone++; f2d = since_fall; end
    prev = pclk;
  end

  bit m_loaded = 1'b0, m_dmem = 1'b0;
  bit e_bit[128], e_oe[128];
  int e_low[128];
  int ne = 0, pl = -1;

  function automatic bit c_has(logic [5:0] c); return c[3:0] inside {4'h0, 4'h2, 4'h3, 4'h4, 4'h5}; endfunction
  function automatic bit c_rd(logic [5:0] c);  return c[3:0] inside {4'h4, 4'h5}; endfunction
  function automatic bit c_ld(logic [5:0] c);  return c[3:0] inside {4'h0, 4'h2, 4'h3}; endfunction
  function automatic bit c_beg(logic [5:0] c); return c[4:0] == 5'b01000; endfunction
  function automatic bit c_era(logic [5:0] c); return c[3:0] inside {4'h9, 4'hB}; endfunction
  function automatic int post_of(logic [5:0] c);
    if (c_beg(c)) return m_dmem ? DPROG : PROG;
    if (c_era(c)) return ERASE;
    return GAP;
  endfunction

  task automatic push(input bit b, input bit oe, input int lw);
    if (ne < 128) begin e_bit[ne] = b; e_oe[ne] = oe; e_low[ne] = lw; end
    ne++;
  endtask

  task automatic run_step(input logic [5:0] c, input logic [13:0] d);
    for (int i = 0; i < 6; i++) push(c[i], 1'b1, (i == 0) ? pl : HALF);
    if (c_has(c))
      for (int i = 0; i < 16; i++)
        push((i == 0 || i == 15) ? 1'b0 : d[i-1], !c_rd(c), (i == 0) ? HALF + GAP : HALF);
    pl = HALF + post_of(c);
    if (c_ld(c)) begin m_loaded = 1'b1; m_dmem = (c[3:0] == 4'h3); end
    if (c_beg(c)) m_loaded = 1'b0;
  endtask

  task automatic do_req(input logic [1:0] k, input logic [5:0] c, input logic [13:0] d,
                        input logic [13:0] dev, input bit poke, input string rq);
    bit exp_err = 1'b0, rd_chk = 1'b0;
    int exp_cyc = -1, cyc, n0, bad;
    ne = 0; pl = -1;
    case (k)
      K_ENTRY: begin m_loaded = 1'b0; exp_cyc = ENTRY + 1; end
      K_ERASE: begin run_step(6'h02, 14'h3FFF); run_step(6'h09, '0); end
      K_PROG: begin
        run_step(6'h02, d); run_step(6'h08, '0); run_step(6'h04, '0); rd_chk = 1'b1;
        if (dev == d) run_step(6'h06, '0); else exp_err = 1'b1;
      end
      default: begin
        if (c_beg(c) && !m_loaded) begin exp_err = 1'b1; exp_cyc = 1; end
        else begin run_step(c, d); rd_chk = c_rd(c); end
      end
    endcase
    rframe = {1'b0, dev, 1'b0};
    @(negedge clk);
    np = 0; hi_bad = 0; n0 = ndone;
    req_valid = 1'b1; req_kind = k; req_cmd = c; req_data = d;
    @(negedge clk);
    req_valid = 1'b0; cyc = 1;
    while (!done && cyc < 4000) begin
      @(negedge clk); cyc++;
      if (poke && cyc == 4) begin req_valid = 1'b1; req_kind = K_ERASE; end
      else req_valid = 1'b0;
    end
    repeat (6) @(negedge clk);
    bad = 0;
    for (int i = 0; i < ne && i < np && i < 128; i++) begin
      if (log_oe[i] != e_oe[i]) bad++;
      if (e_oe[i] && log_bit[i] != e_bit[i]) bad++;
      if (e_low[i] >= 0 && log_low[i] != e_low[i]) bad++;
    end
    chk(np == ne, {rq, " pulse count"}, np, ne);
    chk(bad == 0 && hi_bad == 0, {rq, " bit/oe/gap pattern"}, bad + hi_bad, 0);
    chk(ndone == n0 + 1, {rq, " done count (R10)"}, ndone - n0, 1);
    chk(err == exp_err, {rq, " err"}, err, exp_err);
    if (exp_cyc >= 0) chk(cyc == exp_cyc, {rq, " cycles to done"}, cyc, exp_cyc);
    if (ne > 0) chk(f2d == pl, {rq, " post delay (R5)"}, f2d, pl);
    if (rd_chk) chk(rd_data == dev, {rq, " read word (R4)"}, rd_data, dev);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
  endtask

  initial begin
    #(8 * 150000);
    nchk++; nfail++;
    $display("FAIL watchdog: actual 1 expected 0");
    summary();
    $finish;
  end

  logic [5:0] ops[9] = '{6'h00, 6'h02, 6'h03, 6'h04, 6'h05, 6'h06, 6'h08, 6'h09, 6'h0B};

  initial begin
    int seed_v;
    seed_v = $urandom(32'h5EED);
    repeat (4) @(negedge clk);
    chk(!busy && !done && !pclk && !pdat_o && !mode_en && pdat_oe, "R1 during reset", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !pclk && !pdat_o && !mode_en && pdat_oe, "R1 after reset", pclk, 0);

    do_req(K_ENTRY, '0, '0, '0, 1'b0, "R9 entry");
    chk(mode_en == 1'b1, "R9 mode_en held", mode_en, 1);
    do_req(K_RAW, 6'h08, '0, '0, 1'b0, "R6 begin without load");
    do_req(K_RAW, 6'h02, 14'h1A5C, '0, 1'b0, "R2 R3 load program word");
    do_req(K_RAW, 6'h08, '0, '0, 1'b0, "R5 begin program memory");
    do_req(K_RAW, 6'h03, 14'h00A5, '0, 1'b0, "R3 load data byte");
    do_req(K_RAW, 6'h28, '0, '0, 1'b0, "R5 begin data memory");
    do_req(K_RAW, 6'h04, '0, 14'h2B3C, 1'b0, "R4 read program");
    do_req(K_RAW, 6'h05, '0, 14'h005A, 1'b0, "R4 read data");
    do_req(K_ERASE, '0, '0, '0, 1'b0, "R7 erase macro");
    do_req(K_RAW, 6'h0B, '0, '0, 1'b0, "R5 erase data post");
    do_req(K_PROG, '0, 14'h3C81, 14'h3C81, 1'b0, "R8 verify match");
    do_req(K_PROG, '0, 14'h3C81, 14'h3C80, 1'b0, "R8 verify mismatch");
    do_req(K_RAW, 6'h06, '0, '0, 1'b1, "R10 request while busy");
    do_req(K_RAW, 6'h02, 14'h0001, '0, 1'b0, "R3 load before re-entry");
    do_req(K_ENTRY, '0, '0, '0, 1'b0, "R9 re-entry");
    do_req(K_RAW, 6'h08, '0, '0, 1'b0, "R6 begin after re-entry");

    for (int n = 0; n < 40; n++) begin
      int r;
      logic [5:0] c;
      logic [13:0] d, dev;
      r = $urandom_range(0, 9);
      d = 14'($urandom);
      dev = ($urandom_range(0, 1) == 1) ? d : 14'($urandom);
      c = ops[$urandom_range(0, 8)];
      if (c_beg(c)) c[5] = 1'($urandom);
      else c[5:4] = 2'($urandom);
      if (r == 0) do_req(K_ENTRY, '0, '0, '0, 1'b0, "R9 random entry");
      else if (r == 1) do_req(K_ERASE, '0, '0, '0, 1'b0, "R7 random erase");
      else if (r <= 3) do_req(K_PROG, '0, d, dev, 1'b0, "R8 random verify");
      else do_req(K_RAW, c, d, dev, 1'b0, "R2 R3 R5 R6 random raw");
    end
    chk(mode_en == 1'b1, "R9 mode_en at end", mode_en, 1);
    summary();
    $finish;
  end
endmodule